// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the interlock and squash logic for a single-issue, in-order, five-stage pipeline (fetch, decode, execute, memory, writeback). The pipeline has one memory port that serves both instruction fetch and data access. Each cycle the block looks at the decode stage's source register fields and the destination fields and control bits of the three stages ahead of it. From these it drives the hold, bubble, squash and redirect strobes that the pipeline registers obey in that same cycle. The block is purely combinational from its inputs to its outputs.

The block handles three cases:
- **Read-after-write interlock.** A decode instruction that reads a register still owed by an older in-flight instruction waits in place. Bubbles enter execute until the producer has left writeback. There is no forwarding path.
- **Structural conflict.** A load or store in the memory stage takes the shared port, so fetch cannot run that cycle and a no-op enters the fetch/decode register.
- **Branch mispredict.** A branch in execute whose outcome differs from its prediction squashes both younger stages and steers fetch to the correct address. This case wins over every stall.

Top module: `hzd_unit`

## Requirements
- R1: When decode is valid and a used, nonzero source register equals the destination of a valid, register-writing instruction in execute, then holdPc=1, holdIfId=1 and nopIdEx=1, while nopIfId=0.
- R2: The same interlock as R1 applies when the matching producer is in the memory stage or the writeback stage, since no value is forwarded before writeback completes.
- R3: Register 0 never creates a dependence. A source whose use bit is 0 never creates a dependence. A producer that is invalid or has its register-write bit at 0 never creates a dependence.
- R4: An invalid decode slot never triggers the interlock, whatever its source fields hold.
- R5: A valid memory-stage instruction with its memory-access bit set, with no interlock and no mispredict, gives holdPc=1 and nopIfId=1, with holdIfId=0 and nopIdEx=0.
- R6: A structural conflict together with an interlock gives holdPc=1, holdIfId=1 and nopIdEx=1, with nopIfId=0, so the held decode instruction is kept rather than replaced.
- R7: A mispredict is defined as exValid & exIsBranch & (exTaken != exPredTaken). It gives redirectValid=1, nopIfId=1 and nopIdEx=1, with holdPc=0 and holdIfId=0, whatever interlock or structural condition also holds.
- R8: During a mispredict, redirectPc equals exTarget when exTaken=1 and exSeqPc when exTaken=0. Outside a mispredict, redirectValid=0 and redirectPc=0.
- R9: A branch whose outcome matches its prediction, whether taken or not taken, causes no redirect and no squash.
- R10: With no dependence, no memory-stage access and no mispredict, all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only by the bound checker |
| rstN | input | 1 | Active-low reset; used only by the bound checker |
| decValid | input | 1 | Decode stage holds a real instruction |
| decSrc1 | input | REG_W | First source register in decode |
| decSrc2 | input | REG_W | Second source register in decode |
| decUse1 | input | 1 | First source is actually read |
| decUse2 | input | 1 | Second source is actually read |
| exValid | input | 1 | Execute stage holds a real instruction |
| exRegWrite | input | 1 | Execute instruction writes a register |
| exDest | input | REG_W | Execute destination register |
| exIsBranch | input | 1 | Execute instruction is a conditional branch |
| exTaken | input | 1 | Resolved branch outcome |
| exPredTaken | input | 1 | Outcome the front end predicted |
| exTarget | input | PC_W | Branch target address |
| exSeqPc | input | PC_W | Fall-through address after the branch |
| memValid | input | 1 | Memory stage holds a real instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| memDest | input | REG_W | Memory-stage destination register |
| memAccess | input | 1 | Memory-stage instruction is a load or store |
| wbValid | input | 1 | Writeback stage holds a real instruction |
| wbRegWrite | input | 1 | Writeback instruction writes a register |
| wbDest | input | REG_W | Writeback destination register |
| holdPc | output | 1 | Keep the fetch address unchanged |
| holdIfId | output | 1 | Keep the fetch/decode register unchanged |
| nopIfId | output | 1 | Load a no-op into the fetch/decode register |
| nopIdEx | output | 1 | Load a no-op into the decode/execute register |
| redirectValid | output | 1 | Replace the fetch address with redirectPc |
| redirectPc | output | PC_W | Corrected fetch address |

## Verification
The assertions assume that the stage fields are settled whenever the clock rises. They also assume that the valid and control bits never take unknown values after reset. The bench meets both conditions by changing every input only at the falling edge and holding all of them at 0 while reset is asserted. The stimulus keeps register numbers between 0 and 3, so that matches, including matches on register 0, occur often. It mixes directed cases with a long pseudo-random sweep over every valid, write, use, access and branch bit. Each result is compared against the expected strobes, computed from the rules above.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // Causes detected by the datapath, consumed by the control
  typedef struct packed {
    logic rawHit;
    logic memBusy;
    logic mispredict;
  } hzdCause_t;

  // Strobes from control back to the datapath and the pipeline
  typedef struct packed {
    logic holdPc;
    logic holdDec;
    logic killDec;
    logic killEx;
    logic redirect;
  } hzdStrobe_t;
endpackage

// File: rtl/hzd_datapath.sv
module hzd_datapath
  import hzd_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int PC_W     = 32,
  parameter int NUM_SRC  = 2,
  parameter int NUM_PROD = 3
) (
  input  logic                              decValid,
  input  logic [NUM_SRC-1:0][REG_W-1:0]     decSrc,
  input  logic [NUM_SRC-1:0]                decUse,
  input  logic [NUM_PROD-1:0]               prodValid,
  input  logic [NUM_PROD-1:0]               prodWrite,
  input  logic [NUM_PROD-1:0][REG_W-1:0]    prodDest,
  input  logic                              memValid,
  input  logic                              memAccess,
  input  logic                              exValid,
  input  logic                              exIsBranch,
  input  logic                              exTaken,
  input  logic                              exPredTaken,
  input  logic [PC_W-1:0]                   exTarget,
  input  logic [PC_W-1:0]                   exSeqPc,
  input  hzdStrobe_t                        strobe,
  output hzdCause_t                         cause,
  output logic [PC_W-1:0]                   redirectPc
);
  localparam int NUM_PAIR = NUM_SRC * NUM_PROD;

  logic [NUM_PAIR-1:0] pairHit;

  // One comparator per (source, producer) pair
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      assign pairHit[s*NUM_PROD + p] = decUse[s]
                                     && (decSrc[s] != '0)
                                     && prodValid[p]
                                     && prodWrite[p]
                                     && (prodDest[p] == decSrc[s]);
    end
  end

  always_comb begin
    cause.rawHit     = decValid && (|pairHit);
    cause.memBusy    = memValid && memAccess;
    cause.mispredict = exValid && exIsBranch && (exTaken != exPredTaken);
  end

  always_comb begin
    redirectPc = '0;
    if (strobe.redirect) begin
      redirectPc = exTaken ? exTarget : exSeqPc;
    end
  end
endmodule

// File: rtl/hzd_control.sv
module hzd_control
  import hzd_pkg::*;
(
  input  hzdCause_t  cause,
  output hzdStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (cause.mispredict) begin
      // squash wins over any stall
      strobe.killDec  = 1'b1;
      strobe.killEx   = 1'b1;
      strobe.redirect = 1'b1;
    end else begin
      if (cause.rawHit) begin
        strobe.holdPc  = 1'b1;
        strobe.holdDec = 1'b1;
        strobe.killEx  = 1'b1;
      end
      if (cause.memBusy) begin
        strobe.holdPc  = 1'b1;
        strobe.killDec = !cause.rawHit;
      end
    end
  end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             decValid,
  input  logic [REG_W-1:0] decSrc1,
  input  logic [REG_W-1:0] decSrc2,
  input  logic             decUse1,
  input  logic             decUse2,
  input  logic             exValid,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] exDest,
  input  logic             exIsBranch,
  input  logic             exTaken,
  input  logic             exPredTaken,
  input  logic [PC_W-1:0]  exTarget,
  input  logic [PC_W-1:0]  exSeqPc,
  input  logic             memValid,
  input  logic             memRegWrite,
  input  logic [REG_W-1:0] memDest,
  input  logic             memAccess,
  input  logic             wbValid,
  input  logic             wbRegWrite,
  input  logic [REG_W-1:0] wbDest,
  output logic             holdPc,
  output logic             holdIfId,
  output logic             nopIfId,
  output logic             nopIdEx,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectPc
);
  localparam int NUM_SRC  = 2;
  localparam int NUM_PROD = 3;

  // clock and reset serve the bound checker only
  logic unusedClkRst;
  assign unusedClkRst = clk ^ rstN;

  hzdCause_t  cause;
  hzdStrobe_t strobe;

  logic [NUM_SRC-1:0][REG_W-1:0]  srcVec;
  logic [NUM_SRC-1:0]             useVec;
  logic [NUM_PROD-1:0]            prodValid;
  logic [NUM_PROD-1:0]            prodWrite;
  logic [NUM_PROD-1:0][REG_W-1:0] prodDest;

  assign srcVec    = {decSrc2, decSrc1};
  assign useVec    = {decUse2, decUse1};
  assign prodValid = {wbValid, memValid, exValid};
  assign prodWrite = {wbRegWrite, memRegWrite, exRegWrite};
  assign prodDest  = {wbDest, memDest, exDest};

  hzd_datapath #(
    .REG_W(REG_W), .PC_W(PC_W), .NUM_SRC(NUM_SRC), .NUM_PROD(NUM_PROD)
  ) u_dp (
    .decValid   (decValid),
    .decSrc     (srcVec),
    .decUse     (useVec),
    .prodValid  (prodValid),
    .prodWrite  (prodWrite),
    .prodDest   (prodDest),
    .memValid   (memValid),
    .memAccess  (memAccess),
    .exValid    (exValid),
    .exIsBranch (exIsBranch),
    .exTaken    (exTaken),
    .exPredTaken(exPredTaken),
    .exTarget   (exTarget),
    .exSeqPc    (exSeqPc),
    .strobe     (strobe),
    .cause      (cause),
    .redirectPc (redirectPc)
  );

  hzd_control u_ctl (
    .cause (cause),
    .strobe(strobe)
  );

  assign holdPc        = strobe.holdPc;
  assign holdIfId      = strobe.holdDec;
  assign nopIfId       = strobe.killDec;
  assign nopIdEx       = strobe.killEx;
  assign redirectValid = strobe.redirect;
endmodule

// File: rtl/hzd_checker.sv
module hzd_checker #(
  parameter int REG_W = 5,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             decValid,
  input logic [REG_W-1:0] decSrc1,
  input logic [REG_W-1:0] decSrc2,
  input logic             exValid,
  input logic             exIsBranch,
  input logic             exTaken,
  input logic             exPredTaken,
  input logic [PC_W-1:0]  exTarget,
  input logic [PC_W-1:0]  exSeqPc,
  input logic             memValid,
  input logic             memAccess,
  input logic             holdPc,
  input logic             holdIfId,
  input logic             nopIfId,
  input logic             nopIdEx,
  input logic             redirectValid,
  input logic [PC_W-1:0]  redirectPc
);
  // R7: a squash never coexists with a hold
  p_flush_beats_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (!holdPc && !holdIfId && nopIfId && nopIdEx));

  // R7: a wrong prediction in execute always squashes
  p_mispredict_flush_r7: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exIsBranch && (exTaken != exPredTaken)) |-> redirectValid);

  // R9: a correct prediction never redirects
  p_correct_pred_r9: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exIsBranch && (exTaken == exPredTaken)) |-> !redirectValid);

  // R8: redirect address follows the resolved outcome
  p_redirect_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (redirectPc == (exTaken ? exTarget : exSeqPc)));

  // R8: no stray address when idle
  p_redirect_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |-> (redirectPc == '0));

  // R5: a busy memory port always stops fetch unless squashing
  p_port_conflict_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memAccess && !redirectValid) |-> holdPc);

  // R6: holding decode always sends a bubble forward, never a no-op into decode
  p_hold_bubble_r6: assert property (@(posedge clk) disable iff (!rstN)
    holdIfId |-> (nopIdEx && !nopIfId && holdPc));

  // R4: an empty decode slot never interlocks
  p_empty_decode_r4: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !holdIfId);

  // R3: sources that are both register 0 never interlock
  p_zero_reg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (decSrc1 == '0 && decSrc2 == '0) |-> !holdIfId);
endmodule

bind hzd_unit hzd_checker #(.REG_W(REG_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .decSrc1(decSrc1), .decSrc2(decSrc2),
  .exValid(exValid), .exIsBranch(exIsBranch), .exTaken(exTaken), .exPredTaken(exPredTaken),
  .exTarget(exTarget), .exSeqPc(exSeqPc), .memValid(memValid), .memAccess(memAccess),
  .holdPc(holdPc), .holdIfId(holdIfId), .nopIfId(nopIfId), .nopIdEx(nopIdEx),
  .redirectValid(redirectValid), .redirectPc(redirectPc)
);

// File: tb/tb_hzd_unit.sv
module tb_hzd_unit;
  localparam int REG_W = 5;
  localparam int PC_W  = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic decValid, decUse1, decUse2;
  logic [REG_W-1:0] decSrc1, decSrc2, exDest, memDest, wbDest;
  logic exValid, exRegWrite, exIsBranch, exTaken, exPredTaken;
  logic [PC_W-1:0] exTarget, exSeqPc, redirectPc;
  logic memValid, memRegWrite, memAccess, wbValid, wbRegWrite;
  logic holdPc, holdIfId, nopIfId, nopIdEx, redirectValid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  hzd_unit #(.REG_W(REG_W), .PC_W(PC_W)) dut (.*);

  task automatic idle();
    decValid = 0; decUse1 = 0; decUse2 = 0; decSrc1 = '0; decSrc2 = '0;
    exValid = 0; exRegWrite = 0; exDest = '0; exIsBranch = 0; exTaken = 0;
    exPredTaken = 0; exTarget = '0; exSeqPc = '0;
    memValid = 0; memRegWrite = 0; memDest = '0; memAccess = 0;
    wbValid = 0; wbRegWrite = 0; wbDest = '0;
  endtask

  function automatic logic srcHit(logic u, logic [REG_W-1:0] s);
    logic h;
    h = 1'b0;
    if (u && s != '0) begin
      if (exValid && exRegWrite && exDest == s) h = 1'b1;
      if (memValid && memRegWrite && memDest == s) h = 1'b1;
      if (wbValid && wbRegWrite && wbDest == s) h = 1'b1;
    end
    return h;
  endfunction

  // expected {holdPc, holdIfId, nopIfId, nopIdEx, redirectValid, redirectPc}
  function automatic logic [PC_W+4:0] model();
    logic mis, raw, busy;
    logic [PC_W+4:0] e;
    mis  = exValid && exIsBranch && (exTaken != exPredTaken);
    raw  = decValid && (srcHit(decUse1, decSrc1) || srcHit(decUse2, decSrc2));
    busy = memValid && memAccess;
    if (mis) e = {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, (exTaken ? exTarget : exSeqPc)};
    else     e = {raw || busy, raw, busy && !raw, raw, 1'b0, {PC_W{1'b0}}};
    return e;
  endfunction

  task automatic check(string tag);
    logic [PC_W+4:0] act, exp;
    #2;
    act = {holdPc, holdIfId, nopIfId, nopIdEx, redirectValid, redirectPc};
    exp = model();
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    string tag;
    idle();
    repeat (3) @(negedge clk);
    // reset state: idle inputs, all strobes low
    check("R10");
    rstN = 1'b1;

    // R1: dependence on execute
    @(negedge clk); idle();
    decValid = 1; decUse1 = 1; decSrc1 = 5'd7;
    exValid = 1; exRegWrite = 1; exDest = 5'd7; check("R1");
    // R2: dependence on memory stage (second source)
    @(negedge clk); idle();
    decValid = 1; decUse2 = 1; decSrc2 = 5'd9;
    memValid = 1; memRegWrite = 1; memDest = 5'd9; check("R2");
    // R2: dependence on writeback
    @(negedge clk); idle();
    decValid = 1; decUse1 = 1; decSrc1 = 5'd31;
    wbValid = 1; wbRegWrite = 1; wbDest = 5'd31; check("R2");
    // R3: register 0, unused source, non-writing producer
    @(negedge clk); idle();
    decValid = 1; decUse1 = 1; decUse2 = 1;
    exValid = 1; exRegWrite = 1; exDest = '0; check("R3");
    @(negedge clk); idle();
    decValid = 1; decSrc1 = 5'd4; exValid = 1; exRegWrite = 1; exDest = 5'd4; check("R3");
    @(negedge clk); idle();
    decValid = 1; decUse1 = 1; decSrc1 = 5'd4; memValid = 1; memDest = 5'd4; check("R3");
    // R4: invalid decode
    @(negedge clk); idle();
    decUse1 = 1; decSrc1 = 5'd2; exValid = 1; exRegWrite = 1; exDest = 5'd2; check("R4");
    // R5: load in memory stage
    @(negedge clk); idle();
    memValid = 1; memAccess = 1; check("R5");
    // R6: both
    @(negedge clk); idle();
    memValid = 1; memAccess = 1; memRegWrite = 1; memDest = 5'd3;
    decValid = 1; decUse1 = 1; decSrc1 = 5'd3; check("R6");
    // R7/R8: mispredicts with competing stalls
    @(negedge clk); idle();
    exValid = 1; exIsBranch = 1; exTaken = 0; exPredTaken = 1;
    exTarget = 32'h0000_4000; exSeqPc = 32'h0000_1004;
    memValid = 1; memAccess = 1; check("R7");
    @(negedge clk); idle();
    exValid = 1; exIsBranch = 1; exTaken = 1; exPredTaken = 0; exRegWrite = 1; exDest = 5'd6;
    exTarget = 32'h0000_8800; exSeqPc = 32'h0000_2008;
    decValid = 1; decUse1 = 1; decSrc1 = 5'd6; check("R8");
    // R9: correct predictions, both directions
    @(negedge clk); idle();
    exValid = 1; exIsBranch = 1; exTaken = 1; exPredTaken = 1; exTarget = 32'h10; check("R9");
    @(negedge clk); idle();
    exValid = 1; exIsBranch = 1; exTaken = 0; exPredTaken = 0; exSeqPc = 32'h20; check("R9");
    // R10: fully idle pipeline with harmless traffic
    @(negedge clk); idle();
    decValid = 1; decUse1 = 1; decSrc1 = 5'd1; exValid = 1; exRegWrite = 1; exDest = 5'd2; check("R10");

    // pseudo-random sweep over a small register range
    st = 32'h1ACE_B00C;
    for (int i = 0; i < 20000; i++) begin
      st ^= st << 13; st ^= st >> 17; st ^= st << 5;
      @(negedge clk);
      decValid = st[0]; decUse1 = st[1]; decUse2 = st[2];
      decSrc1 = {3'b0, st[4:3]}; decSrc2 = {3'b0, st[6:5]};
      exValid = st[7]; exRegWrite = st[8]; exDest = {3'b0, st[10:9]};
      memValid = st[11]; memRegWrite = st[12]; memDest = {3'b0, st[14:13]}; memAccess = st[15];
      wbValid = st[16]; wbRegWrite = st[17]; wbDest = {3'b0, st[19:18]};
      exIsBranch = st[20]; exTaken = st[21]; exPredTaken = st[22] ^ st[23];
      exTarget = {st[31:24], 24'h000100}; exSeqPc = {24'h0, st[31:24]};
      if (exValid && exIsBranch && exTaken != exPredTaken) tag = "R7/R8";
      else if (memValid && memAccess) tag = "R5/R6";
      else if (!decValid) tag = "R4";
      else tag = "R1/R2/R3";
      check(tag);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule